// File: doc/BRIEF.md
# Emulated PC Serial Port Register Block

This block presents the byte-wide register set of a PC-style serial port to a simple single-cycle bus. The bus uses a 3-bit offset. Software programs the line and modem controls, a 16-bit divisor, interrupt enables and a scratch byte. It reads back line status, modem status and the pending-interrupt identification. No bit-level serializer exists: a byte written to the data offset leaves at once on a valid/data transmit stream, and the divisor is only stored.

Received bytes come from two sources. The first is a host push port, used when loopback is off. The second is the block's own data writes when loopback is on. Both feed one receive queue that software drains through the data offset. Interrupt causes are kept as OR-ed pending flags. A raised cause produces a one-cycle pulse on a single interrupt output. A read of the identification offset clears every pending flag.

Top module: `serial_port_regs`

## Requirements
- R1: After reset the registers read as follows: identification 0xC1, line status 0x60, line control 0x03, modem control 0x08, modem status 0xB0, interrupt enable 0x00, scratch 0x00 and divisor 12 (0x000C).
- R2: While line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the high byte. In that state neither the transmit stream nor the interrupt enable is touched.
- R3: A read (bus_re high, bus_we low) returns its data on bus_rdata with bus_rvalid exactly one cycle later. When bus_we and bus_re are high together, the write is performed and no read takes place.
- R4: A write to offset 1 keeps only the low four data bits, so bits 7..4 of the interrupt enable always read as zero.
- R5: The identification read value is 0xC0 OR-ed with the pending causes: receive 0x04, transmit-empty 0x02, and 0x01 when nothing is pending. The read clears every pending cause.
- R6: With loopback off, a data write puts the byte on tx_byte with tx_valid one cycle later. Every such write raises the transmit-empty cause when enable bit 1 is set.
- R7: A write to offset 1 raises the receive cause when enable bit 0 is set and the queue holds data. It raises the transmit-empty cause when the low four bits changed and enable bit 1 is set.
- R8: An accepted push raises the receive cause only when enable bit 0 is set and that cause is not already pending. A raise that finds the cause already pending gives no interrupt pulse.
- R9: A data read returns the oldest queued byte, or 0x00 when the queue is empty, and clears the receive cause. Line status bit 0 reads 1 exactly when the queue holds at least one byte.
- R10: With modem control bit 4 set, data writes go into the receive queue and not to the transmit stream. Writes made while 64 bytes are held are dropped, and host pushes are ignored.
- R11: With loopback set, modem status reads {OUT2, OUT1, DTR, RTS, 4'b0000}, taken from modem control bits 3, 2, 0 and 1. Otherwise it reads 0xB0.
- R12: Writes to offsets 2, 5 and 6 change nothing. Line control, modem control and scratch (offset 7) read back the full byte last written.
- R13: irq_pulse is high for one cycle, one cycle after each cycle in which a cause is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| host_push | input | 1 | Push host_byte into the receive queue |
| host_byte | input | 8 | Byte offered by the host |
| tx_valid | output | 1 | Transmitted byte valid |
| tx_byte | output | 8 | Transmitted byte |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
Each read, transmitted byte and interrupt pulse is due exactly one cycle after the clock edge that samples its stimulus. Queue and status effects become visible to a read issued in the following cycle. The bench stamps each expected read and transmit item with the cycle number in which it must appear. The monitor rejects an item that arrives early, late or unrequested. Interrupt pulses are counted continuously and the count is compared on the falling edge after each cause-raising access.

// File: rtl/srp_pkg.sv
package srp_pkg;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam int LCR_DIVSEL_BIT = 7;
  localparam int MCR_LOOP_BIT   = 4;

  localparam logic [7:0] LCR_RESET  = 8'h03;
  localparam logic [7:0] MCR_RESET  = 8'h08;
  localparam logic [7:0] MSR_FIXED  = 8'hB0;
  localparam logic [7:0] LSR_IDLE   = 8'h60;
  localparam logic [7:0] IIR_FORCED = 8'hC0;

  typedef struct packed {
    logic tx_wr;
    logic lb_wr;
    logic data_rd;
    logic ident_rd;
    logic enable_wr;
  } srp_access_t;

endpackage

// File: rtl/srp_cfg_regs.sv
module srp_cfg_regs
  import srp_pkg::*;
#(
  parameter int DIV_RESET = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [3:0]  ier_q,
  output logic [3:0]  ier_eff,
  output logic        ier_chg,
  output logic [7:0]  lcr_q,
  output logic [7:0]  mcr_q,
  output logic [7:0]  scr_q,
  output logic [15:0] div_q
);

  localparam logic [15:0] DIV_RST = 16'(DIV_RESET);

  logic        divsel;
  logic        hit_ier, hit_lcr, hit_mcr, hit_scr, hit_dlo, hit_dhi;
  logic [3:0]  ier_d;
  logic [7:0]  lcr_d, mcr_d, scr_d;
  logic [15:0] div_d;

  always_comb begin
    divsel  = lcr_q[LCR_DIVSEL_BIT];
    hit_ier = wr_en && (addr == OFS_IER) && !divsel;
    hit_dlo = wr_en && (addr == OFS_DATA) && divsel;
    hit_dhi = wr_en && (addr == OFS_IER) && divsel;
    hit_lcr = wr_en && (addr == OFS_LCR);
    hit_mcr = wr_en && (addr == OFS_MCR);
    hit_scr = wr_en && (addr == OFS_SCR);

    ier_d = hit_ier ? wdata[3:0] : ier_q;
    lcr_d = hit_lcr ? wdata : lcr_q;
    mcr_d = hit_mcr ? wdata : mcr_q;
    scr_d = hit_scr ? wdata : scr_q;
    div_d = div_q;
    if (hit_dlo) div_d[7:0]  = wdata;
    if (hit_dhi) div_d[15:8] = wdata;

    ier_eff = ier_d;
    ier_chg = hit_ier && (wdata[3:0] != ier_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= 4'h0;
      lcr_q <= LCR_RESET;
      mcr_q <= MCR_RESET;
      scr_q <= 8'h00;
      div_q <= DIV_RST;
    end else begin
      ier_q <= ier_d;
      lcr_q <= lcr_d;
      mcr_q <= mcr_d;
      scr_q <= scr_d;
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/srp_rx_queue.sv
module srp_rx_queue #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         pop_req,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         push_ok
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    push_ok  = push_req && (cnt < CNT_FULL);
    pop_ok   = pop_req && (cnt != '0);
    wr_ptr_d = push_ok ? bump(wr_ptr) : wr_ptr;
    rd_ptr_d = pop_ok  ? bump(rd_ptr) : rd_ptr;
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt + 1'b1;
      2'b01:   cnt_d = cnt - 1'b1;
      default: cnt_d = cnt;
    endcase
    empty = (cnt == '0);
    head  = mem[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      cnt    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/srp_irq_track.sv
module srp_irq_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_rx,
  input  logic       clr_all,
  input  logic       raise_rx,
  input  logic       raise_thr,
  input  logic       en_rx,
  input  logic       en_thr,
  output logic       rx_pend,
  output logic       thr_pend,
  output logic [7:0] iir_val,
  output logic       irq_pulse
);

  logic rx_kept, thr_kept, rx_fire, thr_fire;
  logic rx_d, thr_d, irq_d;

  always_comb begin
    // bus-side clears are applied first, raises in the same cycle follow
    rx_kept  = rx_pend & ~clr_rx & ~clr_all;
    thr_kept = thr_pend & ~clr_all;
    rx_fire  = raise_rx & en_rx & ~rx_kept;
    thr_fire = raise_thr & en_thr;
    rx_d     = rx_kept | rx_fire;
    thr_d    = thr_kept | thr_fire;
    irq_d    = rx_fire | thr_fire;
    iir_val  = {5'b00000, rx_pend, thr_pend, ~(rx_pend | thr_pend)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pend   <= 1'b0;
      thr_pend  <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      rx_pend   <= rx_d;
      thr_pend  <= thr_d;
      irq_pulse <= irq_d;
    end
  end

endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import srp_pkg::*;
#(
  parameter int RXQ_DEPTH   = 64,
  parameter int DIV_RESET   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rvalid,
  input  logic       host_push,
  input  logic [7:0] host_byte,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       irq_pulse
);

  // reset: asserted asynchronously, released through a synchronizer
  logic rst_sync_n;
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= 1'b1;
      end
      assign rst_sync_n = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = s_q[SYNC_STAGES-1];
    end
  endgenerate

  logic [3:0]  ier_q, ier_eff;
  logic        ier_chg;
  logic [7:0]  lcr_q, mcr_q, scr_q;
  logic [15:0] div_q;
  logic        divsel, loop_mode, rd_fire;
  srp_access_t acc;

  logic [7:0] q_head, push_byte;
  logic       q_empty, q_push_ok, push_req;
  logic       rx_pend, thr_pend;
  logic [7:0] iir_val;
  logic       raise_rx, raise_thr;
  logic [7:0] msr_view, rd_mux;

  srp_cfg_regs #(.DIV_RESET(DIV_RESET)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .ier_q   (ier_q),
    .ier_eff (ier_eff),
    .ier_chg (ier_chg),
    .lcr_q   (lcr_q),
    .mcr_q   (mcr_q),
    .scr_q   (scr_q),
    .div_q   (div_q)
  );

  always_comb begin
    divsel        = lcr_q[LCR_DIVSEL_BIT];
    loop_mode     = mcr_q[MCR_LOOP_BIT];
    rd_fire       = bus_re & ~bus_we;
    acc.tx_wr     = bus_we && (bus_addr == OFS_DATA) && !divsel && !loop_mode;
    acc.lb_wr     = bus_we && (bus_addr == OFS_DATA) && !divsel && loop_mode;
    acc.enable_wr = bus_we && (bus_addr == OFS_IER) && !divsel;
    acc.data_rd   = rd_fire && (bus_addr == OFS_DATA) && !divsel;
    acc.ident_rd  = rd_fire && (bus_addr == OFS_IIR);

    push_req  = acc.lb_wr | (host_push & ~loop_mode);
    push_byte = acc.lb_wr ? bus_wdata : host_byte;
    raise_rx  = q_push_ok | (acc.enable_wr & ~q_empty);
    raise_thr = acc.tx_wr | (acc.enable_wr & ier_chg);
  end

  srp_rx_queue #(.DEPTH(RXQ_DEPTH), .W(8)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_req  (push_req),
    .push_data (push_byte),
    .pop_req   (acc.data_rd),
    .head      (q_head),
    .empty     (q_empty),
    .push_ok   (q_push_ok)
  );

  srp_irq_track u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_rx    (acc.data_rd),
    .clr_all   (acc.ident_rd),
    .raise_rx  (raise_rx),
    .raise_thr (raise_thr),
    .en_rx     (ier_eff[0]),
    .en_thr    (ier_eff[1]),
    .rx_pend   (rx_pend),
    .thr_pend  (thr_pend),
    .iir_val   (iir_val),
    .irq_pulse (irq_pulse)
  );

  // read mux sees the state before this cycle's side effects
  always_comb begin
    msr_view = loop_mode ? {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1], 4'h0} : MSR_FIXED;
    unique case (bus_addr)
      OFS_DATA: rd_mux = divsel ? div_q[7:0]  : (q_empty ? 8'h00 : q_head);
      OFS_IER:  rd_mux = divsel ? div_q[15:8] : {4'h0, ier_q};
      OFS_IIR:  rd_mux = iir_val | IIR_FORCED;
      OFS_LCR:  rd_mux = lcr_q;
      OFS_MCR:  rd_mux = mcr_q;
      OFS_LSR:  rd_mux = LSR_IDLE | {7'h00, ~q_empty};
      OFS_MSR:  rd_mux = msr_view;
      default:  rd_mux = scr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 8'h00;
      tx_valid   <= 1'b0;
      tx_byte    <= 8'h00;
    end else begin
      bus_rvalid <= rd_fire;
      if (rd_fire)   bus_rdata <= rd_mux;
      tx_valid   <= acc.tx_wr;
      if (acc.tx_wr) tx_byte   <= bus_wdata;
    end
  end

endmodule

// File: rtl/serial_port_regs_chk.sv
module serial_port_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic       bus_re,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       bus_rvalid,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       irq_pulse,
  input logic       divsel,
  input logic       loop_mode,
  input logic [3:0] ier_q,
  input logic       rx_pend,
  input logic       q_empty
);

  p_rvalid_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we) |=> bus_rvalid);

  p_no_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_re || bus_we) |=> !bus_rvalid);

  p_ier_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we && bus_addr == 3'd1 && !divsel) |=> (bus_rdata[7:4] == 4'h0));

  p_tx_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_we && bus_addr == 3'd0 && !divsel && !loop_mode));

  p_tx_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_byte == $past(bus_wdata)));

  p_loop_no_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && !divsel && loop_mode) |=> !tx_valid);

  p_rx_pend_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pend |-> !q_empty);

  p_irq_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past((ier_q[1:0] != 2'b00) ||
                        (bus_we && bus_addr == 3'd1 && !divsel && bus_wdata[1:0] != 2'b00)));

endmodule

bind serial_port_regs serial_port_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .tx_valid   (tx_valid),
  .tx_byte    (tx_byte),
  .irq_pulse  (irq_pulse),
  .divsel     (divsel),
  .loop_mode  (loop_mode),
  .ier_q      (ier_q),
  .rx_pend    (rx_pend),
  .q_empty    (q_empty)
);

// File: tb/sim_serial_port_regs.sv
`timescale 1ns/1ps
module sim_serial_port_regs;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_we, bus_re, host_push;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, host_byte;
  logic [7:0] bus_rdata, tx_byte;
  logic       bus_rvalid, tx_valid, irq_pulse;

  always #4 clk = ~clk;

  serial_port_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .host_push(host_push), .host_byte(host_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq_pulse(irq_pulse)
  );

  int tests = 0, fails = 0, cyc = 0, irq_cnt = 0, exp_irq = 0;
  bit done = 0;

  logic [7:0] rd_exp[$];  string rd_tag[$];  int rd_due[$];
  logic [7:0] tx_exp[$];  string tx_tag[$];  int tx_due[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_rvalid) begin
        if (rd_exp.size() == 0) check("R3 unexpected rvalid", 1, 0);
        else begin
          string t = rd_tag.pop_front();
          check(t, bus_rdata, rd_exp.pop_front());
          check({t, " cycle"}, cyc, rd_due.pop_front());
        end
      end
      if (tx_valid) begin
        if (tx_exp.size() == 0) check("R10 unexpected tx", 1, 0);
        else begin
          string t = tx_tag.pop_front();
          check(t, tx_byte, tx_exp.pop_front());
          check({t, " cycle"}, cyc, tx_due.pop_front());
        end
      end
      if (irq_pulse) irq_cnt++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] d, input string tag);
    @(posedge clk); #2;
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = d;
    tx_exp.push_back(d); tx_tag.push_back(tag); tx_due.push_back(cyc + 1);
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #2;
    bus_re = 1'b1; bus_addr = a;
    rd_exp.push_back(e); rd_tag.push_back(tag); rd_due.push_back(cyc + 1);
    @(posedge clk); #2;
    bus_re = 1'b0;
  endtask

  task automatic push_b(input logic [7:0] b);
    @(posedge clk); #2;
    host_push = 1'b1; host_byte = b;
    @(posedge clk); #2;
    host_push = 1'b0;
  endtask

  task automatic chk_irq(input int delta, input string tag);
    exp_irq += delta;
    @(negedge clk); #1;
    check(tag, irq_cnt, exp_irq);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    host_push = 0; host_byte = 0;
    repeat (5) @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(3'd2, 8'hC1, "R1 iir");   rd(3'd5, 8'h60, "R1 lsr");
    rd(3'd3, 8'h03, "R1 lcr");   rd(3'd4, 8'h08, "R1 mcr");
    rd(3'd6, 8'hB0, "R1 msr");   rd(3'd1, 8'h00, "R1 ier");
    rd(3'd7, 8'h00, "R1 scr");
    wr(3'd3, 8'h83);
    rd(3'd0, 8'h0C, "R1 div lo"); rd(3'd1, 8'h00, "R1 div hi");

    // R2 divisor access
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd(3'd0, 8'h34, "R2 div lo"); rd(3'd1, 8'h12, "R2 div hi");
    chk_irq(0, "R2 no irq");
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h00, "R2 ier untouched");
    rd(3'd0, 8'h00, "R9 empty data read");

    // R4 / R7 / R5
    wr(3'd1, 8'hF0); chk_irq(0, "R7 unchanged low bits");
    rd(3'd1, 8'h00, "R4 upper dropped");
    wr(3'd1, 8'h0F); chk_irq(1, "R7 thr on change");
    rd(3'd1, 8'h0F, "R4 low kept");
    rd(3'd2, 8'hC2, "R5 thr pending");
    rd(3'd2, 8'hC1, "R5 cleared by read");

    // R6 transmit
    wr_tx(8'h41, "R6 tx 41"); chk_irq(1, "R6 irq 1");
    wr_tx(8'h42, "R6 tx 42"); chk_irq(1, "R13 irq every write");
    rd(3'd2, 8'hC2, "R5 thr after tx");
    wr(3'd1, 8'h0D); chk_irq(0, "R7 thr disabled");
    wr_tx(8'h43, "R6 tx 43"); chk_irq(0, "R6 no irq when disabled");
    rd(3'd2, 8'hC1, "R5 none");

    // R8 / R9 receive
    wr(3'd1, 8'h01); chk_irq(0, "R7 empty queue");
    push_b(8'h11); chk_irq(1, "R8 first push");
    push_b(8'h22); chk_irq(0, "R8 already pending");
    rd(3'd5, 8'h61, "R9 data ready");
    rd(3'd2, 8'hC4, "R5 rx pending");
    push_b(8'h33); chk_irq(1, "R8 re-raise");
    rd(3'd0, 8'h11, "R9 order 1"); rd(3'd0, 8'h22, "R9 order 2");
    rd(3'd5, 8'h61, "R9 still ready");
    rd(3'd0, 8'h33, "R9 order 3");
    rd(3'd5, 8'h60, "R9 drained");
    rd(3'd0, 8'h00, "R9 empty zero");
    rd(3'd2, 8'hC1, "R9 rx cleared");

    // R7 enable write with data present
    wr(3'd1, 8'h00); push_b(8'h55); chk_irq(0, "R8 disabled");
    wr(3'd1, 8'h01); chk_irq(1, "R7 rx on enable");
    rd(3'd2, 8'hC4, "R7 rx pending");
    rd(3'd0, 8'h55, "R9 data 55");
    wr(3'd1, 8'h03); chk_irq(1, "R7 thr change");
    wr(3'd1, 8'h03); chk_irq(0, "R7 same value");
    rd(3'd2, 8'hC2, "R7 thr pending");

    // R11 loopback modem status
    wr(3'd1, 8'h01);
    wr(3'd4, 8'h10); rd(3'd6, 8'h00, "R11 none");
    wr(3'd4, 8'h1F); rd(3'd6, 8'hF0, "R11 all");
    wr(3'd4, 8'h15); rd(3'd6, 8'h60, "R11 dtr out1");
    wr(3'd4, 8'h1A); rd(3'd6, 8'h90, "R11 rts out2");

    // R10 loopback queue
    push_b(8'h99); rd(3'd5, 8'h60, "R10 host ignored");
    chk_irq(0, "R10 host no irq");
    wr(3'd0, 8'hA0); chk_irq(1, "R10 loop push irq");
    for (int i = 1; i < 64; i++) wr(3'd0, 8'(8'hA0 + i));
    wr(3'd0, 8'hEE);
    chk_irq(0, "R10 no extra irq");
    rd(3'd5, 8'h61, "R10 ready");
    for (int i = 0; i < 64; i++) rd(3'd0, 8'(8'hA0 + i), "R10 loop byte");
    rd(3'd0, 8'h00, "R10 overflow dropped");
    rd(3'd5, 8'h60, "R10 empty");
    rd(3'd2, 8'hC1, "R10 iir");
    wr(3'd4, 8'h08); rd(3'd6, 8'hB0, "R11 stored msr");

    // R12 read-only offsets and scratch
    wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
    rd(3'd5, 8'h60, "R12 lsr"); rd(3'd6, 8'hB0, "R12 msr");
    rd(3'd2, 8'hC1, "R12 iir"); chk_irq(0, "R12 no irq");
    wr(3'd7, 8'h5A); rd(3'd7, 8'h5A, "R12 scratch");
    wr(3'd4, 8'hE8); rd(3'd4, 8'hE8, "R12 mcr full byte");

    // R3 write wins over read
    @(posedge clk); #2;
    bus_we = 1'b1; bus_re = 1'b1; bus_addr = 3'd7; bus_wdata = 8'hA5;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_re = 1'b0;
    rd(3'd7, 8'hA5, "R3 write taken");

    repeat (4) @(negedge clk);
    check("R3 reads outstanding", rd_exp.size(), 0);
    check("R6 tx outstanding", tx_exp.size(), 0);
    check("R13 final irq count", irq_cnt, exp_irq);
    finish_run();
  end

endmodule